// File: doc/BRIEF.md
# Dual-Plane Reference Sequencer

This block is the digital core of a two-rail regulator controller. It produces two 8-bit reference codes at 6.25 mV per LSB, one for the core plane and one for the auxiliary plane, which feed a pair of DACs. On the rising edge of the enable input, after reset has been released, it reads a 2-bit boot code from two pins and stores the matching level. It then ramps both references from zero to that level one LSB per step tick, and raises power-good when both have arrived.

Once power-good is high and the host raises its ready input, the block accepts set-voltage commands that are already decoded. Each command carries a plane mask, a target code and an off request. Each selected reference slews to the new target one LSB per tick. A command that arrives while a plane is still slewing moves that plane's target, and the ramp carries on from the present code. When the host drops its ready input, both planes slew back to the stored boot level and commands are ignored. When ready returns, nothing moves until a new command arrives. Dropping enable shuts the block down.

Top module: `vref_seq`

## Requirements
- R1: The boot pins {boot_clk_pin_i, boot_dat_pin_i} = 00, 01, 10, 11 select the boot codes 176, 160, 144 and 128 (1.1 V, 1.0 V, 0.9 V and 0.8 V).
- R2: The boot pins are sampled once, in the cycle where en_i rises while the block is waiting, and later pin changes do not affect the stored level.
- R3: After enable, both references start at 0 and rise together by exactly 1 on each step tick, with ticks spaced TICK_DIV clock cycles apart, until they reach the boot code.
- R4: pgood_o is low while waiting and during soft-start, and goes high one cycle after both references first equal the boot code.
- R5: Commands are ignored while pgood_o is low, and while host_ok_i is low.
- R6: A command with cmd_valid_i high retargets the core plane if cmd_plane_i[0] is set and the auxiliary plane if cmd_plane_i[1] is set, and each selected reference slews by 1 per tick to cmd_code_i.
- R7: A command with cmd_off_i high and cmd_plane_i[0] set raises core_off_o and slews the core reference to 0, while pgood_o stays high and the auxiliary plane keeps its present target.
- R8: While host_ok_i is low after power-good, both references slew back to the stored boot code, core_off_o clears, and the boot pins are not re-read.
- R9: After host_ok_i rises again, neither reference changes until a new command is accepted.
- R10: A command that arrives during a slew replaces the target, and the ramp continues from the present code without restarting.
- R11: With en_i low, both references are 0 and pgood_o is low from the next clock edge onward, and the block waits for a new enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_i | input | 1 | Enable; its rising edge latches the boot code |
| boot_clk_pin_i | input | 1 | Boot code bit 1 |
| boot_dat_pin_i | input | 1 | Boot code bit 0 |
| host_ok_i | input | 1 | Host ready; high lets commands through, low forces the boot level |
| cmd_valid_i | input | 1 | One-cycle strobe for a decoded set-voltage command |
| cmd_plane_i | input | 2 | Plane mask: bit 0 core, bit 1 auxiliary |
| cmd_code_i | input | CODE_W | Target reference code |
| cmd_off_i | input | 1 | Turn the core plane off (ignored for the auxiliary plane) |
| core_ref_o | output | CODE_W | Core plane reference code |
| aux_ref_o | output | CODE_W | Auxiliary plane reference code |
| core_off_o | output | 1 | Core plane has been commanded off |
| pgood_o | output | 1 | Power-good |

## Verification
The assertions assume that commands carry targets inside the code range and never wrap a reference past zero or full scale. They also assume that reset is asserted before enable is ever raised, so that the first enable edge comes after reset. The bench holds en_i low through reset and chooses every target between 20 and 216. It drives all inputs at falling clock edges, so every command strobe lasts exactly one clock edge and enable edges land cleanly in the waiting state.

// File: rtl/vref_pkg.sv
package vref_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_SOFT = 2'd1,
    ST_ON   = 2'd2
  } seq_state_t;

  localparam int PLANES    = 2;
  localparam int CORE_IDX  = 0;
  localparam int AUX_IDX   = 1;
endpackage

// File: rtl/vref_tick_gen.sv
module vref_tick_gen #(
  parameter int TICK_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cnt_q == LAST) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_space
      p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/vref_slew.sv
module vref_slew #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] tgt_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              at_tgt_o
);
  logic [CODE_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cur_q <= '0;
    end else if (tick_i) begin
      if (cur_q < tgt_i)      cur_q <= cur_q + 1'b1;
      else if (cur_q > tgt_i) cur_q <= cur_q - 1'b1;
    end
  end

  assign ref_o    = cur_q;
  assign at_tgt_o = (cur_q == tgt_i);

  p_one_lsb_step_r3: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (ref_o == $past(ref_o) || ref_o == $past(ref_o) + CODE_W'(1)
                || ref_o == $past(ref_o) - CODE_W'(1)));

  p_no_move_without_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !tick_i) |=> $stable(ref_o));
endmodule

// File: rtl/vref_boot_latch.sv
module vref_boot_latch #(
  parameter int CODE_W    = 8,
  parameter int BOOT_TOP  = 176,
  parameter int BOOT_STEP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [1:0]        pins_i,
  output logic [CODE_W-1:0] decoded_o,
  output logic [CODE_W-1:0] level_o
);
  logic [CODE_W-1:0] level_q;

  assign decoded_o = CODE_W'(BOOT_TOP - int'(pins_i) * BOOT_STEP);

  always_ff @(posedge clk) begin
    if (rst)            level_q <= '0;
    else if (capture_i) level_q <= decoded_o;
  end

  assign level_o = level_q;

  p_level_only_on_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(level_o));
endmodule

// File: rtl/vref_seq.sv
module vref_seq #(
  parameter int CODE_W    = 8,
  parameter int TICK_DIV  = 64,
  parameter int BOOT_TOP  = 176,
  parameter int BOOT_STEP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              boot_clk_pin_i,
  input  logic              boot_dat_pin_i,
  input  logic              host_ok_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_plane_i,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              cmd_off_i,
  output logic [CODE_W-1:0] core_ref_o,
  output logic [CODE_W-1:0] aux_ref_o,
  output logic              core_off_o,
  output logic              pgood_o
);
  import vref_pkg::*;

  seq_state_t                    state_q;
  logic                          en_prev_q;
  logic                          en_rise;
  logic                          capture;
  logic                          pgood_q;
  logic                          core_off_q;
  logic [PLANES-1:0][CODE_W-1:0] tgt_q;
  logic [PLANES-1:0][CODE_W-1:0] ref_w;
  logic [PLANES-1:0]             at_w;
  logic [CODE_W-1:0]             boot_dec;
  logic [CODE_W-1:0]             boot_lvl;
  logic                          tick;

  assign en_rise = en_i && !en_prev_q;
  assign capture = (state_q == ST_WAIT) && en_rise;

  vref_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  vref_boot_latch #(
    .CODE_W(CODE_W), .BOOT_TOP(BOOT_TOP), .BOOT_STEP(BOOT_STEP)
  ) u_boot (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .pins_i    ({boot_clk_pin_i, boot_dat_pin_i}),
    .decoded_o (boot_dec),
    .level_o   (boot_lvl)
  );

  generate
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
      vref_slew #(.CODE_W(CODE_W)) u_slew (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (!en_i),
        .tick_i   (tick),
        .tgt_i    (tgt_q[p]),
        .ref_o    (ref_w[p]),
        .at_tgt_o (at_w[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) en_prev_q <= 1'b0;
    else     en_prev_q <= en_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state_q    <= ST_WAIT;
      tgt_q      <= '0;
      core_off_q <= 1'b0;
      pgood_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (en_rise) begin
            tgt_q[CORE_IDX] <= boot_dec;
            tgt_q[AUX_IDX]  <= boot_dec;
            state_q         <= ST_SOFT;
          end
        end
        ST_SOFT: begin
          if (&at_w) begin
            pgood_q <= 1'b1;
            state_q <= ST_ON;
          end
        end
        ST_ON: begin
          if (!host_ok_i) begin
            tgt_q[CORE_IDX] <= boot_lvl;
            tgt_q[AUX_IDX]  <= boot_lvl;
            core_off_q      <= 1'b0;
          end else if (cmd_valid_i) begin
            if (cmd_plane_i[CORE_IDX]) begin
              core_off_q      <= cmd_off_i;
              tgt_q[CORE_IDX] <= cmd_off_i ? '0 : cmd_code_i;
            end
            if (cmd_plane_i[AUX_IDX] && !cmd_off_i) begin
              tgt_q[AUX_IDX] <= cmd_code_i;
            end
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign core_ref_o = ref_w[CORE_IDX];
  assign aux_ref_o  = ref_w[AUX_IDX];
  assign core_off_o = core_off_q;
  assign pgood_o    = pgood_q;

  p_pgood_at_boot_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood_o) |-> (core_ref_o == boot_lvl && aux_ref_o == boot_lvl));

  p_no_pgood_while_waiting_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> !pgood_o);

  p_off_keeps_pgood_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && en_i && host_ok_i && cmd_valid_i && cmd_off_i) |=> pgood_o);

  p_fallback_target_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && en_i && !host_ok_i) |=>
      (tgt_q[CORE_IDX] == boot_lvl && tgt_q[AUX_IDX] == boot_lvl && !core_off_o));

  p_disable_clears_r11: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (core_ref_o == '0 && aux_ref_o == '0 && !pgood_o));
endmodule

// File: tb/vref_seq_test.sv
module vref_seq_test;
  localparam int TD     = 3;
  localparam int SETTLE = 256 * TD + 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic       boot_clk_pin_i = 1'b0;
  logic       boot_dat_pin_i = 1'b0;
  logic       host_ok_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [1:0] cmd_plane_i = 2'b00;
  logic [7:0] cmd_code_i = 8'd0;
  logic       cmd_off_i = 1'b0;
  logic [7:0] core_ref_o;
  logic [7:0] aux_ref_o;
  logic       core_off_o;
  logic       pgood_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  vref_seq #(.CODE_W(8), .TICK_DIV(TD), .BOOT_TOP(176), .BOOT_STEP(16)) uut (
    .clk(clk), .rst(rst), .en_i(en_i),
    .boot_clk_pin_i(boot_clk_pin_i), .boot_dat_pin_i(boot_dat_pin_i),
    .host_ok_i(host_ok_i), .cmd_valid_i(cmd_valid_i), .cmd_plane_i(cmd_plane_i),
    .cmd_code_i(cmd_code_i), .cmd_off_i(cmd_off_i),
    .core_ref_o(core_ref_o), .aux_ref_o(aux_ref_o),
    .core_off_o(core_off_o), .pgood_o(pgood_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] plane, input int code, input logic off);
    cmd_valid_i = 1'b1;
    cmd_plane_i = plane;
    cmd_code_i  = 8'(code);
    cmd_off_i   = off;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    cmd_plane_i = 2'b00;
    cmd_off_i   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk(core_ref_o == 0 && aux_ref_o == 0, "reset refs", core_ref_o, 0);
    chk(pgood_o == 0 && core_off_o == 0, "reset flags", pgood_o, 0);
    rst = 1'b0;
    wait_cyc(2);

    for (int b = 0; b < 4; b++) begin
      int exp;
      int cyc;
      int prev;
      int last_chg;
      int nchg;
      int reach;
      int pg_cyc;
      bit step_ok;
      bit space_ok;
      bit sync_ok;
      int v;
      int w;
      bit pg_held;

      exp = 176 - 16 * b;
      {boot_clk_pin_i, boot_dat_pin_i} = 2'(b);
      host_ok_i = 1'b0;
      en_i = 1'b1;
      @(negedge clk);
      {boot_clk_pin_i, boot_dat_pin_i} = 2'(~b);   // R2: later pin changes ignored
      cyc = 0; prev = 0; last_chg = 0; nchg = 0; reach = -1; pg_cyc = -1;
      step_ok = 1; space_ok = 1; sync_ok = 1;
      while (pg_cyc < 0 && cyc < 300 * TD) begin
        cyc++;
        if (cyc == 10) begin
          host_ok_i = 1'b1;
          cmd_valid_i = 1'b1; cmd_plane_i = 2'b11; cmd_code_i = 8'd60;
        end else begin
          cmd_valid_i = 1'b0; cmd_plane_i = 2'b00;
        end
        @(negedge clk);
        if (aux_ref_o != core_ref_o) sync_ok = 0;
        if (int'(core_ref_o) != prev) begin
          if (int'(core_ref_o) != prev + 1) step_ok = 0;
          if (nchg > 0 && cyc - last_chg != TD) space_ok = 0;
          nchg++;
          last_chg = cyc;
          prev = core_ref_o;
        end
        if (reach < 0 && int'(core_ref_o) == exp) reach = cyc;
        if (pgood_o) pg_cyc = cyc;
      end
      cmd_valid_i = 1'b0;
      chk(int'(core_ref_o) == exp && int'(aux_ref_o) == exp, "R1 boot level", core_ref_o, exp);
      chk(int'(core_ref_o) == exp, "R2 pins changed after edge", core_ref_o, exp);
      chk(step_ok && nchg == exp, "R3 one LSB per step", nchg, exp);
      chk(space_ok && sync_ok, "R3 tick spacing and both planes together", last_chg, exp * TD);
      chk(reach > 0 && pg_cyc == reach + 1, "R4 pgood one cycle after target", pg_cyc, reach + 1);
      chk(int'(core_ref_o) == exp, "R5 command during soft-start ignored", core_ref_o, exp);

      host_ok_i = 1'b0;
      wait_cyc(2);
      send(2'b11, 40, 1'b0);
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == exp && int'(aux_ref_o) == exp, "R5 command with host_ok low ignored", core_ref_o, exp);

      host_ok_i = 1'b1;
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == exp && int'(aux_ref_o) == exp, "R9 no change before command", core_ref_o, exp);

      send(2'b01, exp + 20, 1'b0);
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == exp + 20 && int'(aux_ref_o) == exp, "R6 core only", core_ref_o, exp + 20);
      send(2'b10, exp - 50, 1'b0);
      wait_cyc(SETTLE);
      chk(int'(aux_ref_o) == exp - 50 && int'(core_ref_o) == exp + 20, "R6 aux only", aux_ref_o, exp - 50);
      send(2'b11, exp + 30, 1'b0);
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == exp + 30 && int'(aux_ref_o) == exp + 30, "R6 both planes", aux_ref_o, exp + 30);

      send(2'b01, 20, 1'b0);
      wait_cyc(10 * TD);
      v = core_ref_o;
      chk(v < exp + 30 && v >= exp + 30 - 12, "R10 descending before retarget", v, exp + 20);
      send(2'b01, exp + 40, 1'b0);
      wait_cyc(3 * TD);
      w = core_ref_o;
      chk(w > v && w <= v + 5, "R10 continues from present code", w, v + 3);
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == exp + 40, "R10 reaches new target", core_ref_o, exp + 40);

      send(2'b11, 90, 1'b1);
      pg_held = 1;
      for (int k = 0; k < SETTLE; k++) begin
        @(negedge clk);
        if (!pgood_o) pg_held = 0;
      end
      chk(pg_held, "R7 pgood held after core off", pgood_o, 1);
      chk(core_ref_o == 0 && core_off_o == 1, "R7 core off", core_ref_o, 0);
      chk(int'(aux_ref_o) == exp + 30, "R7 aux unchanged", aux_ref_o, exp + 30);

      host_ok_i = 1'b0;
      wait_cyc(2);
      send(2'b11, 30, 1'b0);
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == exp && int'(aux_ref_o) == exp, "R8 fallback to stored boot", core_ref_o, exp);
      chk(core_off_o == 0 && pgood_o == 1, "R8 off flag cleared", core_off_o, 0);

      host_ok_i = 1'b1;
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == exp && int'(aux_ref_o) == exp, "R9 reassert waits", aux_ref_o, exp);
      send(2'b11, 100 + b, 1'b0);
      wait_cyc(SETTLE);
      chk(int'(core_ref_o) == 100 + b && int'(aux_ref_o) == 100 + b, "R9 command after reassert", core_ref_o, 100 + b);

      en_i = 1'b0;
      host_ok_i = 1'b0;
      @(negedge clk);
      chk(core_ref_o == 0 && aux_ref_o == 0, "R11 disable clears refs", core_ref_o, 0);
      chk(pgood_o == 0 && core_off_o == 0, "R11 disable clears pgood", pgood_o, 0);
      wait_cyc(4 * TD);
      chk(core_ref_o == 0 && pgood_o == 0, "R11 stays waiting", core_ref_o, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule